// File: doc/BRIEF.md
# Video-Mode Line and Frame Sequencer for a Display Serial Link

This block produces the timing schedule a display serial link follows in video mode. It counts byte-clock cycles inside each line and lines inside each frame. At every region or packet boundary it raises a one-cycle strobe together with an event code. The codes are frame sync, line sync, blanking, pixel packet, null packet and low-power period. A downstream packetizer turns each event into traffic on the lanes.

Horizontal timing is given in byte-clock cycles and vertical timing in lines. The active part of a line can be split into a number of pixel chunks. In non-burst modes each chunk is followed by a null packet. Every blanking region has its own enable for dropping the link into low power. All configuration inputs are captured while the soft reset input is held low and are ignored while it is high. The sequencer starts a new frame in the first cycle after soft reset is released.

Top module: `dsi_video_sequencer`

## Requirements
- R1: Configuration inputs are captured on every clock while `soft_rst_ni` is low. While `soft_rst_ni` is high, changes on any configuration input have no effect on the event stream.
- R2: While `soft_rst_ni` is low, and from the clock edge after it goes low, no strobe is raised. The first cycle after the edge that samples it high carries a frame sync event.
- R3: Every line lasts `line_time_i` cycles and begins with a sync event: code 1 (frame sync) on the first line of a frame and code 2 (line sync) on every other line.
- R4: `hblk_i` holds the sync-active length in bits [31:16] and the back-porch length in bits [15:0]. With sync pulses (mode 0) or burst mode, the back-porch event comes at cycle HSA of the line. With sync events (mode 1), it comes at cycle 1. Pixel data starts at cycle HSA+HBP in every mode.
- R5: `vblk_i` holds front porch in bits [9:0], back porch in bits [19:10] and sync-active in bits [29:20], all in lines. A frame runs through sync-active lines, then back-porch lines, then `vact_i` active lines, then front-porch lines, and then repeats.
- R6: In modes 0 and 1, an active line carries `chunk_cnt_i` pixel packets (code 4) of `pkt_len_i` cycles each. A null packet (code 5) of the null length in cycles follows each pixel packet when that length is non-zero. The front-porch event comes right after the last packet.
- R7: A null length above 1023 is clamped to 1023 cycles.
- R8: In burst mode (mode 2 or 3), each active line carries exactly one pixel packet and no null packet, whatever the chunk count and null length inputs say.
- R9: A chunk count of zero gives a single pixel packet with no null packet.
- R10: On lines outside the active lines, the event at the back-porch point covers the rest of the line. Its code is 6 (low power) when the enable for that vertical region is set, and 3 (blanking) otherwise. The enable bits are: `lp_en_i[0]` sync-active lines, `[1]` back-porch lines, `[2]` front-porch lines.
- R11: On active lines, the back-porch event is low power only when `lp_en_i[4]` and `lp_en_i[3]` are both set, and blanking otherwise. The front-porch event is low power only when `lp_en_i[5]` and `lp_en_i[3]` are both set, and blanking otherwise.
- R12: `evt_o` is 0 in every cycle without a strobe. With a strobe it is one of the codes 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_ni | input | 1 | Soft reset, active low; configuration is captured while low |
| hblk_i | input | 2*HW | Sync-active [31:16] and back-porch [15:0] lengths in cycles |
| line_time_i | input | HW | Total line length in cycles |
| vblk_i | input | 3*VW | Sync-active, back-porch and front-porch line counts |
| vact_i | input | VAW | Active line count |
| lp_en_i | input | 6 | Low-power enables per region |
| mode_i | input | 2 | 0 sync pulses, 1 sync events, 2/3 burst |
| pkt_len_i | input | HW | Pixel packet length in cycles |
| chunk_cnt_i | input | CW | Pixel chunks per active line |
| null_len_i | input | HW | Null packet length in cycles |
| evt_vld_o | output | 1 | Event strobe |
| evt_o | output | 3 | Event code |

## Verification
The bench sweeps six small configurations over two whole frames each and compares every cycle with an arithmetic model. A design that placed the back-porch point wrongly in sync-event mode would show the blanking event at cycle HSA instead of cycle 1. A design that let burst mode keep the chunk settings would emit extra pixel and null packets. A design that did not clamp the null length would push the front-porch event 977 cycles too late. Other targets are a zero chunk count, a low-power enable masked by the active-line enable, and input changes while running, where a design that failed to hold its captured configuration would bend the schedule mid-frame.

// File: rtl/dsi_vseq_pkg.sv
package dsi_vseq_pkg;
  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_FSYNC = 3'd1,
    EV_LSYNC = 3'd2,
    EV_BLANK = 3'd3,
    EV_PIXEL = 3'd4,
    EV_NULL  = 3'd5,
    EV_LP    = 3'd6
  } evt_e;

  typedef enum logic [1:0] {
    VR_SYNC = 2'd0,
    VR_BACK = 2'd1,
    VR_ACT  = 2'd2,
    VR_FRONT = 2'd3
  } vreg_e;

  localparam int LP_VSA = 0;
  localparam int LP_VBP = 1;
  localparam int LP_VFP = 2;
  localparam int LP_ACT = 3;
  localparam int LP_HBP = 4;
  localparam int LP_HFP = 5;
endpackage

// File: rtl/dsi_vseq_cfg.sv
module dsi_vseq_cfg #(
  parameter int HW       = 16,
  parameter int VW       = 10,
  parameter int VAW      = 12,
  parameter int CW       = 16,
  parameter int NULL_MAX = 1023,
  localparam int NW      = $clog2(NULL_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [2*HW-1:0] hblk_i,
  input  logic [HW-1:0]   line_time_i,
  input  logic [3*VW-1:0] vblk_i,
  input  logic [VAW-1:0]  vact_i,
  input  logic [5:0]      lp_en_i,
  input  logic [1:0]      mode_i,
  input  logic [HW-1:0]   pkt_len_i,
  input  logic [CW-1:0]   chunk_cnt_i,
  input  logic [HW-1:0]   null_len_i,
  output logic [HW-1:0]   hsa_o,
  output logic [HW-1:0]   hbp_o,
  output logic [HW-1:0]   line_o,
  output logic [VW-1:0]   vsa_o,
  output logic [VW-1:0]   vbp_o,
  output logic [VW-1:0]   vfp_o,
  output logic [VAW-1:0]  vact_o,
  output logic [5:0]      lp_o,
  output logic            evmode_o,
  output logic [HW-1:0]   pkt_o,
  output logic [CW-1:0]   chunks_o,
  output logic [NW-1:0]   null_o
);
  logic burst, single;
  assign burst  = mode_i[1];
  assign single = burst || (chunk_cnt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsa_o <= '0; hbp_o <= '0; line_o <= '0;
      vsa_o <= '0; vbp_o <= '0; vfp_o <= '0; vact_o <= '0;
      lp_o <= '0; evmode_o <= 1'b0; pkt_o <= '0;
      chunks_o <= CW'(1); null_o <= '0;
    end else if (load_i) begin
      hsa_o    <= hblk_i[2*HW-1:HW];
      hbp_o    <= hblk_i[HW-1:0];
      line_o   <= line_time_i;
      vfp_o    <= vblk_i[VW-1:0];
      vbp_o    <= vblk_i[2*VW-1:VW];
      vsa_o    <= vblk_i[3*VW-1:2*VW];
      vact_o   <= vact_i;
      lp_o     <= lp_en_i;
      evmode_o <= (mode_i == 2'b01);
      pkt_o    <= pkt_len_i;
      chunks_o <= single ? CW'(1) : chunk_cnt_i;
      if (single)                       null_o <= '0;
      else if (null_len_i > HW'(NULL_MAX)) null_o <= NW'(NULL_MAX);
      else                              null_o <= null_len_i[NW-1:0];
    end
  end
endmodule

// File: rtl/dsi_vseq_timer.sv
module dsi_vseq_timer
  import dsi_vseq_pkg::*;
#(
  parameter int HW  = 16,
  parameter int VW  = 10,
  parameter int VAW = 12,
  localparam int FW = ((VW > VAW) ? VW : VAW) + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [HW-1:0]  line_i,
  input  logic [VW-1:0]  vsa_i,
  input  logic [VW-1:0]  vbp_i,
  input  logic [VW-1:0]  vfp_i,
  input  logic [VAW-1:0] vact_i,
  output logic [HW-1:0]  hcnt_o,
  output logic           first_line_o,
  output logic           line_end_o,
  output vreg_e          vreg_o
);
  logic [FW-1:0] vcnt_q, b_back, b_act, b_front, b_total;

  assign b_back  = FW'(vsa_i);
  assign b_act   = b_back + FW'(vbp_i);
  assign b_front = b_act + FW'(vact_i);
  assign b_total = b_front + FW'(vfp_i);

  assign line_end_o   = run_i && (hcnt_o == line_i - HW'(1));
  assign first_line_o = (vcnt_q == '0);

  always_comb begin
    if (vcnt_q < b_back)       vreg_o = VR_SYNC;
    else if (vcnt_q < b_act)   vreg_o = VR_BACK;
    else if (vcnt_q < b_front) vreg_o = VR_ACT;
    else                       vreg_o = VR_FRONT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o <= '0;
      vcnt_q <= '0;
    end else if (!run_i) begin
      hcnt_o <= '0;
      vcnt_q <= '0;
    end else if (line_end_o) begin
      hcnt_o <= '0;
      vcnt_q <= (vcnt_q == b_total - FW'(1)) ? '0 : vcnt_q + FW'(1);
    end else begin
      hcnt_o <= hcnt_o + HW'(1);
    end
  end
endmodule

// File: rtl/dsi_vseq_chunk.sv
module dsi_vseq_chunk #(
  parameter int HW = 16,
  parameter int CW = 16,
  parameter int NW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [HW-1:0] pkt_i,
  input  logic [NW-1:0] null_i,
  input  logic [CW-1:0] chunks_i,
  output logic          pix_o,
  output logic          null_o,
  output logic          done_o
);
  logic          busy_q, in_null_q, tick;
  logic [HW-1:0] cnt_q;
  logic [CW-1:0] left_q;

  assign tick   = busy_q && (cnt_q == '0);
  assign null_o = tick && !in_null_q && (null_i != '0);
  assign pix_o  = start_i || (tick && !null_o && (left_q != '0));
  assign done_o = tick && !null_o && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; in_null_q <= 1'b0; cnt_q <= '0; left_q <= '0;
    end else if (!run_i || abort_i) begin
      busy_q <= 1'b0; in_null_q <= 1'b0;
    end else if (pix_o) begin
      busy_q    <= 1'b1;
      in_null_q <= 1'b0;
      cnt_q     <= pkt_i - HW'(1);
      left_q    <= start_i ? chunks_i - CW'(1) : left_q - CW'(1);
    end else if (null_o) begin
      in_null_q <= 1'b1;
      cnt_q     <= HW'(null_i) - HW'(1);
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - HW'(1);
    end
  end
endmodule

// File: rtl/dsi_video_sequencer.sv
module dsi_video_sequencer
  import dsi_vseq_pkg::*;
#(
  parameter int HW       = 16,
  parameter int VW       = 10,
  parameter int VAW      = 12,
  parameter int CW       = 16,
  parameter int NULL_MAX = 1023,
  localparam int NW      = $clog2(NULL_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            soft_rst_ni,
  input  logic [2*HW-1:0] hblk_i,
  input  logic [HW-1:0]   line_time_i,
  input  logic [3*VW-1:0] vblk_i,
  input  logic [VAW-1:0]  vact_i,
  input  logic [5:0]      lp_en_i,
  input  logic [1:0]      mode_i,
  input  logic [HW-1:0]   pkt_len_i,
  input  logic [CW-1:0]   chunk_cnt_i,
  input  logic [HW-1:0]   null_len_i,
  output logic            evt_vld_o,
  output logic [2:0]      evt_o
);
  logic [HW-1:0]  hsa, hbp, line_len, pkt, hcnt_q, hb_pt;
  logic [VW-1:0]  vsa, vbp, vfp;
  logic [VAW-1:0] vact;
  logic [5:0]     lp;
  logic           evmode, run_q, first_line, line_end;
  logic [CW-1:0]  chunks;
  logic [NW-1:0]  null_len;
  logic [HW:0]    act_st;
  vreg_e          vreg;
  logic           start, pix, nul, done, blank_lp;
  evt_e           evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= soft_rst_ni;
  end

  dsi_vseq_cfg #(.HW(HW), .VW(VW), .VAW(VAW), .CW(CW), .NULL_MAX(NULL_MAX)) u_cfg (
    .clk_i, .rst_ni, .load_i(!soft_rst_ni),
    .hblk_i, .line_time_i, .vblk_i, .vact_i, .lp_en_i, .mode_i,
    .pkt_len_i, .chunk_cnt_i, .null_len_i,
    .hsa_o(hsa), .hbp_o(hbp), .line_o(line_len), .vsa_o(vsa), .vbp_o(vbp),
    .vfp_o(vfp), .vact_o(vact), .lp_o(lp), .evmode_o(evmode), .pkt_o(pkt),
    .chunks_o(chunks), .null_o(null_len)
  );

  dsi_vseq_timer #(.HW(HW), .VW(VW), .VAW(VAW)) u_tmr (
    .clk_i, .rst_ni, .run_i(run_q), .line_i(line_len),
    .vsa_i(vsa), .vbp_i(vbp), .vfp_i(vfp), .vact_i(vact),
    .hcnt_o(hcnt_q), .first_line_o(first_line), .line_end_o(line_end), .vreg_o(vreg)
  );

  assign hb_pt  = evmode ? HW'(1) : hsa;
  assign act_st = {1'b0, hsa} + {1'b0, hbp};
  assign start  = run_q && (vreg == VR_ACT) && ({1'b0, hcnt_q} == act_st);

  dsi_vseq_chunk #(.HW(HW), .CW(CW), .NW(NW)) u_chk_eng (
    .clk_i, .rst_ni, .run_i(run_q), .start_i(start), .abort_i(line_end),
    .pkt_i(pkt), .null_i(null_len), .chunks_i(chunks),
    .pix_o(pix), .null_o(nul), .done_o(done)
  );

  // low-power choice for the back-porch point of a blanking line
  always_comb begin
    unique case (vreg)
      VR_SYNC:  blank_lp = lp[LP_VSA];
      VR_BACK:  blank_lp = lp[LP_VBP];
      VR_FRONT: blank_lp = lp[LP_VFP];
      default:  blank_lp = lp[LP_HBP] && lp[LP_ACT];
    endcase
  end

  always_comb begin
    evt = EV_NONE;
    if (run_q) begin
      if (hcnt_q == '0)       evt = first_line ? EV_FSYNC : EV_LSYNC;
      else if (hcnt_q == hb_pt) evt = blank_lp ? EV_LP : EV_BLANK;
      else if (pix)           evt = EV_PIXEL;
      else if (nul)           evt = EV_NULL;
      else if (done)          evt = (lp[LP_HFP] && lp[LP_ACT]) ? EV_LP : EV_BLANK;
    end
  end

  assign evt_o     = evt;
  assign evt_vld_o = (evt != EV_NONE);
endmodule

// File: rtl/dsi_vseq_checker.sv
module dsi_vseq_checker #(
  parameter int HW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          soft_rst_ni,
  input logic          run_q,
  input logic [HW-1:0] hcnt_q,
  input logic          evt_vld_o,
  input logic [2:0]    evt_o
);
  p_idle_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_vld_o |-> evt_o == 3'd0);

  p_code_range_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_vld_o |-> (evt_o >= 3'd1 && evt_o <= 3'd6));

  p_quiet_soft_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_ni |=> !evt_vld_o);

  p_first_fsync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_ni) |=> (evt_vld_o && evt_o == 3'd1));

  p_line_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && hcnt_q == '0) |-> (evt_vld_o && (evt_o == 3'd1 || evt_o == 3'd2)));

  p_null_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_o && evt_o == 3'd5) |=> !(evt_vld_o && evt_o == 3'd5));
endmodule

bind dsi_video_sequencer dsi_vseq_checker #(.HW(HW)) u_vseq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_ni(soft_rst_ni), .run_q(run_q),
  .hcnt_q(hcnt_q), .evt_vld_o(evt_vld_o), .evt_o(evt_o)
);

// File: tb/tb_dsi_video_sequencer.sv
module tb_dsi_video_sequencer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_ni = 1'b0;
  logic [31:0] hblk_i = '0;
  logic [15:0] line_time_i = '0;
  logic [29:0] vblk_i = '0;
  logic [11:0] vact_i = '0;
  logic [5:0]  lp_en_i = '0;
  logic [1:0]  mode_i = '0;
  logic [15:0] pkt_len_i = '0;
  logic [15:0] chunk_cnt_i = '0;
  logic [15:0] null_len_i = '0;
  logic        evt_vld_o;
  logic [2:0]  evt_o;

  int checks = 0;
  int fails = 0;
  int c_hsa, c_hbp, c_line, c_vsa, c_vbp, c_vact, c_vfp, c_pkt, c_null, c_chunks, c_mode;
  logic [5:0] c_lp;

  always #10 clk_i = ~clk_i;

  dsi_video_sequencer dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic model(input int v, input int h, output bit vld, output int code,
                       output string req);
    int hb, act, ch, nl, per, d, r0, reg_v;
    bit burst;
    hb    = (c_mode == 1) ? 1 : c_hsa;
    act   = c_hsa + c_hbp;
    burst = (c_mode >= 2);
    ch    = (burst || c_chunks == 0) ? 1 : c_chunks;
    nl    = (burst || c_chunks == 0) ? 0 : ((c_null > 1023) ? 1023 : c_null);
    per   = c_pkt + nl;
    vld = 1'b0; code = 0; req = "R12";
    if (v < c_vsa) reg_v = 0;
    else if (v < c_vsa + c_vbp) reg_v = 1;
    else if (v < c_vsa + c_vbp + c_vact) reg_v = 2;
    else reg_v = 3;
    if (h == 0) begin
      vld = 1'b1; code = (v == 0) ? 1 : 2; req = "R3 R5";
    end else if (reg_v != 2) begin
      if (h == hb) begin
        vld = 1'b1; code = c_lp[(reg_v == 3) ? 2 : reg_v] ? 6 : 3; req = "R4 R5 R10";
      end
    end else if (h == hb) begin
      vld = 1'b1; code = (c_lp[4] && c_lp[3]) ? 6 : 3; req = "R4 R11";
    end else if (h >= act) begin
      d = h - act;
      if (d < ch * per) begin
        r0 = d % per;
        if (r0 == 0) begin
          vld = 1'b1; code = 4;
          req = burst ? "R8" : ((c_chunks == 0) ? "R9" : "R6");
        end else if (nl > 0 && r0 == c_pkt) begin
          vld = 1'b1; code = 5; req = (c_null > 1023) ? "R7" : "R6";
        end
      end else if (d == ch * per) begin
        vld = 1'b1; code = (c_lp[5] && c_lp[3]) ? 6 : 3; req = "R11 R6";
      end
    end
  endtask

  task automatic drive_cfg();
    hblk_i      = {c_hsa[15:0], c_hbp[15:0]};
    line_time_i = c_line[15:0];
    vblk_i      = {c_vsa[9:0], c_vbp[9:0], c_vfp[9:0]};
    vact_i      = c_vact[11:0];
    lp_en_i     = c_lp;
    mode_i      = c_mode[1:0];
    pkt_len_i   = c_pkt[15:0];
    chunk_cnt_i = c_chunks[15:0];
    null_len_i  = c_null[15:0];
  endtask

  task automatic run_cfg(input int frames, input int scramble_at);
    int v, h, tot, ncyc, code;
    bit vld;
    string req;
    @(negedge clk_i);
    soft_rst_ni = 1'b0;
    drive_cfg();
    repeat (3) @(negedge clk_i);
    soft_rst_ni = 1'b1;
    @(posedge clk_i);
    tot  = c_vsa + c_vbp + c_vact + c_vfp;
    ncyc = frames * tot * c_line;
    v = 0; h = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk_i);
      if (i == scramble_at) begin
        hblk_i = 32'h0001_0001; line_time_i = 16'd7; vblk_i = '0; vact_i = 12'd9;
        lp_en_i = ~c_lp; mode_i = ~c_mode[1:0]; pkt_len_i = 16'd1;
        chunk_cnt_i = 16'd5; null_len_i = 16'd1;
      end
      model(v, h, vld, code, req);
      if (scramble_at >= 0 && i >= scramble_at) req = {"R1 ", req};
      check(evt_vld_o == vld && int'(evt_o) == code, req,
            $sformatf("line %0d cycle %0d strobe %0b/%0b code", v, h, evt_vld_o, vld),
            int'(evt_o), code);
      if (h == c_line - 1) begin
        h = 0;
        v = (v == tot - 1) ? 0 : v + 1;
      end else h++;
    end
    // soft reset mid-run silences the stream
    @(negedge clk_i);
    soft_rst_ni = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      check(!evt_vld_o && evt_o == 3'd0, "R2", "strobe during soft reset",
            int'(evt_vld_o), 0);
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(!evt_vld_o && evt_o == 3'd0, "R2", "strobe in reset", int'(evt_vld_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!evt_vld_o && evt_o == 3'd0, "R2", "strobe before release", int'(evt_vld_o), 0);

    // sync pulses, two chunks with nulls, no low power; inputs scrambled mid-run
    c_hsa = 2; c_hbp = 3; c_line = 24; c_pkt = 4; c_null = 2; c_chunks = 2; c_mode = 0;
    c_vsa = 1; c_vbp = 1; c_vact = 2; c_vfp = 1; c_lp = 6'b000000;
    run_cfg(2, 120);

    // sync events, three chunks, every low-power enable set
    c_hsa = 3; c_hbp = 2; c_line = 30; c_pkt = 3; c_null = 4; c_chunks = 3; c_mode = 1;
    c_vsa = 2; c_vbp = 1; c_vact = 3; c_vfp = 2; c_lp = 6'b111111;
    run_cfg(2, -1);

    // burst mode ignores chunk and null settings
    c_hsa = 2; c_hbp = 2; c_line = 20; c_pkt = 6; c_null = 5; c_chunks = 3; c_mode = 2;
    c_vsa = 1; c_vbp = 2; c_vact = 2; c_vfp = 1; c_lp = 6'b101010;
    run_cfg(2, -1);

    // zero chunk count means a single chunk without null
    c_hsa = 1; c_hbp = 2; c_line = 16; c_pkt = 5; c_null = 7; c_chunks = 0; c_mode = 0;
    c_vsa = 1; c_vbp = 1; c_vact = 2; c_vfp = 2; c_lp = 6'b010101;
    run_cfg(2, -1);

    // null length clamp
    c_hsa = 2; c_hbp = 3; c_line = 1100; c_pkt = 3; c_null = 2000; c_chunks = 1; c_mode = 0;
    c_vsa = 1; c_vbp = 0; c_vact = 2; c_vfp = 1; c_lp = 6'b011000;
    run_cfg(2, -1);

    // alternate burst code, front-porch low power masked by active enable
    c_hsa = 3; c_hbp = 1; c_line = 18; c_pkt = 7; c_null = 3; c_chunks = 2; c_mode = 3;
    c_vsa = 2; c_vbp = 1; c_vact = 3; c_vfp = 1; c_lp = 6'b100111;
    run_cfg(2, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule